// File: doc/BRIEF.md
# Nonvolatile Commit Sequencer

This block copies a small set of live register bytes into nonvolatile storage once a bus write transaction has finished. The bus interface gives it a one-cycle strobe on the STOP condition that closes a write. From then on the sequencer reports busy. The bus interface uses that flag to refuse to acknowledge its address, so a host can poll until the storage is free again.

A commit always reprograms every location: the two wiper bytes and the configuration byte. It does this even when only one of them changed. The bytes are captured into a holding bank at the moment the commit begins, so later updates to the live registers cannot tear a commit that is already running. The locations are written one at a time through a simple write port, and each one is given a programming window of a fixed number of clock cycles. When zero-crossing gating is enabled, the commit waits until the zero-crossing detector reports that it has finished. A strobe that arrives while the block is busy is remembered and triggers exactly one more full commit.

Top module: `nvc_commit_top`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are low and no write happens until a strobe arrives.
- R2: Without a `wr_done_i` strobe the block stays idle: `busy_o` stays low and `mem_we_o` is never asserted.
- R3: Each commit issues exactly NUM_LOC single-cycle write pulses, with `mem_addr_o` 0, 1, 2 in that order. Address 0 is wiper 0, address 1 is wiper 1 and address 2 is the configuration byte. Each byte comes from `live_i[8*a +: 8]` for address a.
- R4: Consecutive write pulses of one commit are PROG_CYCLES cycles apart. With gating disabled, the first pulse comes in the cycle right after the clock edge that samples the strobe.
- R5: With gating disabled, `busy_o` is high for exactly NUM_LOC*PROG_CYCLES cycles after the strobe edge, and low afterwards.
- R6: With `zc_en_i` high at the strobe, no write occurs and `busy_o` stays high until `zc_done_i` is sampled high. The first write pulse then comes in the following cycle.
- R7: Written data equals `live_i` as sampled on the edge where the commit starts. Changes to `live_i` after that edge have no effect on the bytes written.
- R8: Strobes that arrive while busy are merged into a single pending request. That request starts one more full commit immediately after the current one, with `busy_o` held high throughout and a fresh capture of `live_i`.
- R9: A write pulse only occurs while `busy_o` is high, and `mem_addr_o` stays below NUM_LOC whenever it does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_done_i | input | 1 | One-cycle strobe: STOP ended a write transaction |
| zc_en_i | input | 1 | Hold the commit start until zero-crossing completes |
| zc_done_i | input | 1 | Zero-crossing detection finished |
| live_i | input | NUM_LOC*DATA_W | Live register bytes, location a at bits [DATA_W*a +: DATA_W] |
| mem_we_o | output | 1 | Write pulse to the storage port |
| mem_addr_o | output | ADDR_W | Location being programmed |
| mem_wdata_o | output | DATA_W | Byte being programmed |
| busy_o | output | 1 | Commit in progress or waiting; bus must not acknowledge |

## Verification
On every cycle the assertions check several invariants. The slot counter and location index stay in range, and a write pulse never appears outside busy. The holding bank stays frozen except on a load. An idle sequencer leaves idle only on a strobe. A pending request always carries busy across the end of a commit, and the gated wait never falls through to programming without a completion signal. Only the bench scenarios can show the cycle placement of each pulse, the exact busy length, and the bytes actually written. They also cover live data changing mid-commit and the merging of several strobes into one extra commit.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ZWAIT = 2'd1,
    ST_PROG  = 2'd2
  } nvc_state_e;

  // total cycles one commit keeps the programming port occupied
  function automatic int unsigned commit_len(input int unsigned locs,
                                             input int unsigned per_loc);
    return locs * per_loc;
  endfunction

  // cycle offset of a location's write pulse from the commit start
  function automatic int unsigned slot_offset(input int unsigned loc,
                                              input int unsigned per_loc);
    return loc * per_loc;
  endfunction

endpackage

// File: rtl/nvc_slot_timer.sv
module nvc_slot_timer #(
  parameter int unsigned PROG_CYCLES = 4,
  parameter int unsigned NUM_LOC     = 3,
  localparam int unsigned CNT_W      = $clog2(PROG_CYCLES + 1),
  localparam int unsigned IDX_W      = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  output logic             slot_first_o,
  output logic [IDX_W-1:0] slot_idx_o,
  output logic             commit_end_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_LOC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             slot_end;

  assign slot_end     = run_i && (cnt_q == CNT_LAST);
  assign slot_first_o = run_i && (cnt_q == '0);
  assign slot_idx_o   = idx_q;
  assign commit_end_o = slot_end && (idx_q == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (slot_end) begin
      cnt_q <= '0;
      idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST);

  // R9
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_LAST);

  generate
    if (PROG_CYCLES > 1) begin : g_spacing
      // R4
      pulse_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_first_o |=> !slot_first_o);
    end
  endgenerate

endmodule

// File: rtl/nvc_hold_bank.sv
module nvc_hold_bank #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_LOC = 3,
  localparam int unsigned IDX_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1,
  localparam int unsigned BUS_W  = DATA_W * NUM_LOC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BUS_W-1:0]  live_i,
  input  logic [IDX_W-1:0]  sel_i,
  output logic [DATA_W-1:0] byte_o
);

  logic [BUS_W-1:0] bank_flat;

  generate
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
      logic [DATA_W-1:0] held_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      held_q <= '0;
        else if (load_i) held_q <= live_i[g*DATA_W +: DATA_W];
      end
      assign bank_flat[g*DATA_W +: DATA_W] = held_q;
    end
  endgenerate

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (sel_i == IDX_W'(i)) byte_o = bank_flat[i*DATA_W +: DATA_W];
    end
  end

  // R7
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(bank_flat));

endmodule

// File: rtl/nvc_ctrl_fsm.sv
module nvc_ctrl_fsm
  import nvc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_done_i,
  input  logic zc_en_i,
  input  logic zc_done_i,
  input  logic commit_end_i,
  output logic run_o,
  output logic load_o,
  output logic busy_o
);

  nvc_state_e state_q, state_d, start_st;
  logic       pend_q, pend_d;
  logic       restart_req;
  logic       zc_released;

  assign start_st    = zc_en_i ? ST_ZWAIT : ST_PROG;
  assign restart_req = pend_q || wr_done_i;
  assign zc_released = zc_done_i || !zc_en_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (wr_done_i) state_d = start_st;
      ST_ZWAIT: if (zc_released) state_d = ST_PROG;
      ST_PROG:  if (commit_end_i) state_d = restart_req ? start_st : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (state_q == ST_PROG && commit_end_i) pend_d = 1'b0;
    else if (wr_done_i && state_q != ST_IDLE) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign run_o  = (state_q == ST_PROG);
  assign busy_o = (state_q != ST_IDLE);
  assign load_o = (state_d == ST_PROG) && ((state_q != ST_PROG) || commit_end_i);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !wr_done_i) |=> !busy_o);

  // R5
  strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && wr_done_i) |=> busy_o);

  // R8
  pend_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && commit_end_i) |=> busy_o);

  // R8
  pend_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> busy_o);

  // R6
  zc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ZWAIT && zc_en_i && !zc_done_i) |=> !run_o);

endmodule

// File: rtl/nvc_commit_top.sv
module nvc_commit_top
  import nvc_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned NUM_LOC     = 3,
  parameter int unsigned PROG_CYCLES = 4,
  localparam int unsigned ADDR_W     = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1,
  localparam int unsigned BUS_W      = DATA_W * NUM_LOC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_done_i,
  input  logic              zc_en_i,
  input  logic              zc_done_i,
  input  logic [BUS_W-1:0]  live_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o
);

  // internal events brought out for the checks below
  logic              ev_run;
  logic              ev_load;
  logic              ev_slot_first;
  logic              ev_commit_end;
  logic [ADDR_W-1:0] ev_slot_idx;

  nvc_ctrl_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_done_i    (wr_done_i),
    .zc_en_i      (zc_en_i),
    .zc_done_i    (zc_done_i),
    .commit_end_i (ev_commit_end),
    .run_o        (ev_run),
    .load_o       (ev_load),
    .busy_o       (busy_o)
  );

  nvc_slot_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .NUM_LOC     (NUM_LOC)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (ev_run),
    .slot_first_o (ev_slot_first),
    .slot_idx_o   (ev_slot_idx),
    .commit_end_o (ev_commit_end)
  );

  nvc_hold_bank #(
    .DATA_W  (DATA_W),
    .NUM_LOC (NUM_LOC)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (ev_load),
    .live_i (live_i),
    .sel_i  (ev_slot_idx),
    .byte_o (mem_wdata_o)
  );

  assign mem_we_o   = ev_slot_first;
  assign mem_addr_o = ev_slot_idx;

  // R9
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);

  // R3
  we_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_addr_o < ADDR_W'(NUM_LOC)));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!busy_o && !mem_we_o));

endmodule

// File: tb/nvc_commit_top_tb_top.sv
`timescale 1ns/1ps
module nvc_commit_top_tb_top;

  localparam int T = 4;
  localparam int L = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_done_i = 1'b0;
  logic        zc_en_i = 1'b0;
  logic        zc_done_i = 1'b0;
  logic [23:0] live_i = '0;
  logic        mem_we_o;
  logic [1:0]  mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        busy_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int n_wr = 0;
  int log_a [64];
  int log_d [64];
  int log_c [64];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nvc_commit_top #(.DATA_W(8), .NUM_LOC(L), .PROG_CYCLES(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_done_i(wr_done_i), .zc_en_i(zc_en_i),
    .zc_done_i(zc_done_i), .live_i(live_i), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .busy_o(busy_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (mem_we_o && n_wr < 64) begin
      log_a[n_wr] <= int'(mem_addr_o);
      log_d[n_wr] <= int'(mem_wdata_o);
      log_c[n_wr] <= cyc;
      n_wr <= n_wr + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_until(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic pulse_wr();
    wr_done_i = 1'b1;
    @(negedge clk);
    wr_done_i = 1'b0;
  endtask

  // checks one commit's pulses from log index base, first pulse at cycle c0
  task automatic check_commit(input int base, input int c0, input logic [23:0] v, input string tag);
    for (int i = 0; i < L; i++) begin
      check(log_a[base+i] == i, {tag, " R3 addr"}, log_a[base+i], i);
      check(log_d[base+i] == int'(v[8*i +: 8]), {tag, " R7 data"}, log_d[base+i], int'(v[8*i +: 8]));
      check(log_c[base+i] == c0 + i*T, {tag, " R4 pulse cycle"}, log_c[base+i], c0 + i*T);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(busy_o == 1'b0, "R1 busy in reset", busy_o, 0);
    check(mem_we_o == 1'b0, "R1 we in reset", mem_we_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R1 busy after reset", busy_o, 0);
  endtask

  task automatic t_idle_quiet();
    int base = n_wr;
    int bc = 0;
    live_i = 24'h123456;
    for (int k = 0; k < 20; k++) begin
      if (busy_o) bc++;
      @(negedge clk);
    end
    check(n_wr == base, "R2 no writes while idle", n_wr - base, 0);
    check(bc == 0, "R2 busy while idle", bc, 0);
  endtask

  task automatic t_basic();
    int base = n_wr;
    int c;
    int bc = 0;
    logic [23:0] v = 24'hC3B2A1;
    live_i = v;
    pulse_wr();
    c = cyc;
    for (int k = 0; k < L*T + 4; k++) begin
      if (busy_o) bc++;
      @(negedge clk);
    end
    check(n_wr - base == L, "R3 pulse count", n_wr - base, L);
    check_commit(base, c, v, "basic");
    check(bc == L*T, "R5 busy length", bc, L*T);
    check(busy_o == 1'b0, "R5 busy released", busy_o, 0);
  endtask

  task automatic t_freeze();
    int base = n_wr;
    int c;
    logic [23:0] v = 24'h0F7E5D;
    live_i = v;
    pulse_wr();
    c = cyc;
    live_i = 24'hFFFFFF;
    repeat (T + 1) @(negedge clk);
    live_i = 24'h000000;
    wait_until(c + L*T + 3);
    check(n_wr - base == L, "R7 pulse count", n_wr - base, L);
    check_commit(base, c, v, "freeze");
  endtask

  task automatic t_zc_gate();
    int base = n_wr;
    int cz;
    logic [23:0] v = 24'h99AA55;
    zc_en_i = 1'b1;
    live_i = 24'h111111;
    pulse_wr();
    repeat (8) @(negedge clk);
    check(n_wr == base, "R6 no write before zc done", n_wr - base, 0);
    check(busy_o == 1'b1, "R6 busy while waiting", busy_o, 1);
    live_i = v;
    zc_done_i = 1'b1;
    @(negedge clk);
    zc_done_i = 1'b0;
    cz = cyc;
    wait_until(cz + L*T - 1);
    check(busy_o == 1'b1, "R6 busy until last slot", busy_o, 1);
    @(negedge clk);
    check(busy_o == 1'b0, "R6 busy released", busy_o, 0);
    repeat (2) @(negedge clk);
    check(n_wr - base == L, "R6 pulse count", n_wr - base, L);
    check_commit(base, cz, v, "zc");
    zc_en_i = 1'b0;
  endtask

  task automatic t_pending();
    int base = n_wr;
    int c;
    logic [23:0] v1 = 24'h332211;
    logic [23:0] v2 = 24'h665544;
    live_i = v1;
    pulse_wr();
    c = cyc;
    repeat (2) @(negedge clk);
    live_i = v2;
    pulse_wr();
    @(negedge clk);
    pulse_wr();
    wait_until(c + L*T);
    check(busy_o == 1'b1, "R8 busy across restart", busy_o, 1);
    wait_until(c + 2*L*T - 1);
    check(busy_o == 1'b1, "R8 busy through second commit", busy_o, 1);
    @(negedge clk);
    check(busy_o == 1'b0, "R8 busy released after one extra", busy_o, 0);
    repeat (L*T + 2) @(negedge clk);
    check(n_wr - base == 2*L, "R8 merged pulse count", n_wr - base, 2*L);
    check_commit(base, c, v1, "pend first");
    check_commit(base + L, c + L*T, v2, "pend second");
    check(busy_o == 1'b0, "R8 no third commit", busy_o, 0);
  endtask

  initial begin
    t_reset();
    t_idle_quiet();
    t_basic();
    t_freeze();
    t_zc_gate();
    t_pending();
    t_basic();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule